// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block drives the raster timing of one display pipe. A horizontal counter advances once per pixel clock while the generator is enabled, and a vertical counter advances each time the horizontal counter wraps. Both counters begin at zero, where the sync pulses start. Register-programmed totals and blanking positions decide where the horizontal and vertical blanking windows lie. Border widths inside those windows mark the overscan areas. The block produces sync, blank and data-enable flags, and it chooses the output pixel from the incoming pixel, a programmed overscan colour, a programmed blank colour, or black.

Software writes all settings through a simple register port, and the same port reads them back. It can also read the live counter position, a vertical-blank status bit and a frame count. A request to blank the output is held until the next frame start. A read-only state bit tells software when the blank has actually reached the output. A request to unblank follows the same rule.

Top module: `raster_timing_gen`

## Requirements
- R1: While enabled, the horizontal count rises by one each clock. After it reaches the value in the horizontal-total register it returns to 0, so a line lasts total+1 clocks. The vertical count advances only when the horizontal count wraps, and it returns to 0 after reaching the vertical-total value.
- R2: After reset, both counts and the frame count are 0. While the run bit (bit 0 at address 0x0) is 0, the counts and the frame count hold their values.
- R3: On each axis the blank flag (hblank_o, vblank_o) is 1 when the count is below the blank-end position or at or above the blank-start position.
- R4: de_o is 1 only when both counts lie inside their blanking limits and outside both borders. Inside the limits, a count is in the border when it is below blank-end plus the low-side border, or at or above blank-start minus the high-side border.
- R5: hsync_o is 1 while the horizontal count is below HSYNC_W. vsync_o is 1 while the vertical count is below VSYNC_W.
- R6: pix_o packs R/Cr in [23:16], G/Y in [15:8] and B/Cb in [7:0]; both colour registers use this same layout. With no blank applied, pix_o shows three things. Outside the blanking limits it is 0. In a border area it is the overscan colour (0x8). In the active area it is pix_i.
- R7: Writing bit 0 of the blank register (0x6) requests blanking. A change to this bit takes effect only when both counters wrap together at a frame start. Bit 8 of the same register reads the applied state. While blanking is applied, pix_o inside the limits is the blank colour (0x7). Unblanking waits for a frame start in the same way.
- R8: When bit 1 of the blank register is set and blanking is applied, de_o is held at 0.
- R9: The status register (0x9) bit 0 equals vblank_o. The position register (0xA) returns the horizontal count in [15:0] and the vertical count in [31:16] in a single read, and two reads one clock apart differ while the generator is running.
- R10: The frame count (0xB) rises by exactly one at each frame start, and it never changes at any other time.
- R11: If a count is at or above its total, it returns to 0 on its next step. This holds even when the total has just been lowered below the current count.
- R12: Register map: 0x1 holds the horizontal total minus one, and 0x2 holds the vertical total minus one. 0x3 holds the horizontal blank end in [15:0] and the blank start in [31:16]. 0x4 holds the same two positions for the vertical axis. 0x5 holds the borders: left [7:0], right [15:8], top [23:16] and bottom [31:24]. Every writable register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pix_i | input | 3*CW | Incoming pixel |
| pix_o | output | 3*CW | Outgoing pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking window |
| vblank_o | output | 1 | Vertical blanking window |
| de_o | output | 1 | Data enable |

## Verification
Two complete frames are scanned with a pixel stream that encodes the current position. Because of that encoding, a passed-through pixel can be told apart from black, from the overscan colour and from a shifted position. The scan checks every flag on every clock against positions that the bench counts itself. The blank request is written in the middle of a frame. The bench then checks that the output is unchanged until the next frame start and replaced after it, then repeats the check for unblanking and for the data-enable mode. A total that is lowered below the live count shows whether the wrap compare is an equality or a bound. Stopping the run bit checks that the position and frame count freeze.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL   = 4'h0,
    A_HTOT   = 4'h1,
    A_VTOT   = 4'h2,
    A_HBLK   = 4'h3,
    A_VBLK   = 4'h4,
    A_BORDER = 4'h5,
    A_BLANK  = 4'h6,
    A_BLKCOL = 4'h7,
    A_OVSCOL = 4'h8,
    A_STATUS = 4'h9,
    A_POS    = 4'hA,
    A_FRAMES = 4'hB
  } reg_addr_e;

  localparam int LO_FLD      = 0;
  localparam int HI_FLD      = 16;
  localparam int BLANK_REQ_B = 0;
  localparam int DE_MODE_B   = 1;
  localparam int CUR_BLANK_B = 8;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int BW      = 8,
  parameter int CW      = 8,
  parameter int FRAME_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [REG_DW-1:0]   wdata_i,
  output logic [REG_DW-1:0]   rdata_o,
  output logic                run_o,
  output logic [CNT_W-1:0]    htot_o,
  output logic [CNT_W-1:0]    vtot_o,
  output logic [CNT_W-1:0]    hb_end_o,
  output logic [CNT_W-1:0]    hb_start_o,
  output logic [CNT_W-1:0]    vb_end_o,
  output logic [CNT_W-1:0]    vb_start_o,
  output logic [BW-1:0]       bdr_l_o,
  output logic [BW-1:0]       bdr_r_o,
  output logic [BW-1:0]       bdr_t_o,
  output logic [BW-1:0]       bdr_b_o,
  output logic                blank_req_o,
  output logic                de_mode_o,
  output logic [3*CW-1:0]     blank_col_o,
  output logic [3*CW-1:0]     ovs_col_o,
  input  logic                cur_blank_i,
  input  logic                vblank_i,
  input  logic [CNT_W-1:0]    hpos_i,
  input  logic [CNT_W-1:0]    vpos_i,
  input  logic [FRAME_W-1:0]  frames_i
);
  localparam int PX_W = 3 * CW;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o       <= 1'b0;
      htot_o      <= '0;
      vtot_o      <= '0;
      hb_end_o    <= '0;
      hb_start_o  <= '0;
      vb_end_o    <= '0;
      vb_start_o  <= '0;
      bdr_l_o     <= '0;
      bdr_r_o     <= '0;
      bdr_t_o     <= '0;
      bdr_b_o     <= '0;
      blank_req_o <= 1'b0;
      de_mode_o   <= 1'b0;
      blank_col_o <= '0;
      ovs_col_o   <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL:   run_o <= wdata_i[0];
        A_HTOT:   htot_o <= wdata_i[CNT_W-1:0];
        A_VTOT:   vtot_o <= wdata_i[CNT_W-1:0];
        A_HBLK: begin
          hb_end_o   <= wdata_i[LO_FLD +: CNT_W];
          hb_start_o <= wdata_i[HI_FLD +: CNT_W];
        end
        A_VBLK: begin
          vb_end_o   <= wdata_i[LO_FLD +: CNT_W];
          vb_start_o <= wdata_i[HI_FLD +: CNT_W];
        end
        A_BORDER: begin
          bdr_l_o <= wdata_i[0    +: BW];
          bdr_r_o <= wdata_i[BW   +: BW];
          bdr_t_o <= wdata_i[2*BW +: BW];
          bdr_b_o <= wdata_i[3*BW +: BW];
        end
        A_BLANK: begin
          blank_req_o <= wdata_i[BLANK_REQ_B];
          de_mode_o   <= wdata_i[DE_MODE_B];
        end
        A_BLKCOL: blank_col_o <= wdata_i[PX_W-1:0];
        A_OVSCOL: ovs_col_o   <= wdata_i[PX_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[0] = run_o;
      A_HTOT: rdata_o[CNT_W-1:0] = htot_o;
      A_VTOT: rdata_o[CNT_W-1:0] = vtot_o;
      A_HBLK: begin
        rdata_o[LO_FLD +: CNT_W] = hb_end_o;
        rdata_o[HI_FLD +: CNT_W] = hb_start_o;
      end
      A_VBLK: begin
        rdata_o[LO_FLD +: CNT_W] = vb_end_o;
        rdata_o[HI_FLD +: CNT_W] = vb_start_o;
      end
      A_BORDER: rdata_o[4*BW-1:0] = {bdr_b_o, bdr_t_o, bdr_r_o, bdr_l_o};
      A_BLANK: begin
        rdata_o[BLANK_REQ_B] = blank_req_o;
        rdata_o[DE_MODE_B]   = de_mode_o;
        rdata_o[CUR_BLANK_B] = cur_blank_i;
      end
      A_BLKCOL: rdata_o[PX_W-1:0] = blank_col_o;
      A_OVSCOL: rdata_o[PX_W-1:0] = ovs_col_o;
      A_STATUS: rdata_o[0] = vblank_i;
      A_POS: begin
        rdata_o[LO_FLD +: CNT_W] = hpos_i;
        rdata_o[HI_FLD +: CNT_W] = vpos_i;
      end
      A_FRAMES: rdata_o[FRAME_W-1:0] = frames_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int CNT_W  = 12,
  parameter int BW     = 8,
  parameter int SYNC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] b_end_i,
  input  logic [CNT_W-1:0] b_start_i,
  input  logic [BW-1:0]    bdr_lo_i,
  input  logic [BW-1:0]    bdr_hi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             blank_o,
  output logic             border_o,
  output logic             sync_o
);
  logic [CNT_W-1:0] lo_edge, hi_edge;

  // bound compare so a lowered total still wraps
  assign wrap_o = cnt_o >= total_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (step_i) cnt_o <= wrap_o ? '0 : cnt_o + CNT_W'(1);
  end

  assign lo_edge  = b_end_i + CNT_W'(bdr_lo_i);
  assign hi_edge  = b_start_i - CNT_W'(bdr_hi_i);
  assign blank_o  = (cnt_o < b_end_i) || (cnt_o >= b_start_i);
  assign border_o = (cnt_o < lo_edge) || (cnt_o >= hi_edge);
  assign sync_o   = cnt_o < CNT_W'(SYNC_W);
endmodule

// File: rtl/rtg_pixel.sv
module rtg_pixel #(
  parameter int CW = 8
) (
  input  logic            in_lim_i,
  input  logic            border_i,
  input  logic            cur_blank_i,
  input  logic            de_mode_i,
  input  logic [3*CW-1:0] pix_i,
  input  logic [3*CW-1:0] blank_col_i,
  input  logic [3*CW-1:0] ovs_col_i,
  output logic [3*CW-1:0] pix_o,
  output logic            de_o
);
  always_comb begin
    if (!in_lim_i)        pix_o = '0;
    else if (cur_blank_i) pix_o = blank_col_i;
    else if (border_i)    pix_o = ovs_col_i;
    else                  pix_o = pix_i;
  end

  assign de_o = in_lim_i && !border_i && !(cur_blank_i && de_mode_i);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int BW      = 8,
  parameter int CW      = 8,
  parameter int FRAME_W = 16,
  parameter int HSYNC_W = 2,
  parameter int VSYNC_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic [3*CW-1:0]   pix_i,
  output logic [3*CW-1:0]   pix_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              de_o
);
  logic               run, blank_req, de_mode, cur_blank;
  logic [CNT_W-1:0]   htot, vtot, hb_end, hb_start, vb_end, vb_start;
  logic [BW-1:0]      bdr_l, bdr_r, bdr_t, bdr_b;
  logic [3*CW-1:0]    blank_col, ovs_col;
  logic [CNT_W-1:0]   hcnt, vcnt;
  logic               h_wrap, v_wrap, h_bdr, v_bdr, frame_end;
  logic [FRAME_W-1:0] frame_cnt;

  rtg_regs #(.CNT_W(CNT_W), .BW(BW), .CW(CW), .FRAME_W(FRAME_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .run_o(run), .htot_o(htot), .vtot_o(vtot),
    .hb_end_o(hb_end), .hb_start_o(hb_start), .vb_end_o(vb_end), .vb_start_o(vb_start),
    .bdr_l_o(bdr_l), .bdr_r_o(bdr_r), .bdr_t_o(bdr_t), .bdr_b_o(bdr_b),
    .blank_req_o(blank_req), .de_mode_o(de_mode),
    .blank_col_o(blank_col), .ovs_col_o(ovs_col),
    .cur_blank_i(cur_blank), .vblank_i(vblank_o),
    .hpos_i(hcnt), .vpos_i(vcnt), .frames_i(frame_cnt)
  );

  rtg_axis #(.CNT_W(CNT_W), .BW(BW), .SYNC_W(HSYNC_W)) u_h (
    .clk_i, .rst_ni, .step_i(run),
    .total_i(htot), .b_end_i(hb_end), .b_start_i(hb_start),
    .bdr_lo_i(bdr_l), .bdr_hi_i(bdr_r),
    .cnt_o(hcnt), .wrap_o(h_wrap), .blank_o(hblank_o), .border_o(h_bdr), .sync_o(hsync_o)
  );

  rtg_axis #(.CNT_W(CNT_W), .BW(BW), .SYNC_W(VSYNC_W)) u_v (
    .clk_i, .rst_ni, .step_i(run && h_wrap),
    .total_i(vtot), .b_end_i(vb_end), .b_start_i(vb_start),
    .bdr_lo_i(bdr_t), .bdr_hi_i(bdr_b),
    .cnt_o(vcnt), .wrap_o(v_wrap), .blank_o(vblank_o), .border_o(v_bdr), .sync_o(vsync_o)
  );

  assign frame_end = run && h_wrap && v_wrap;

  // blank state and frame count move only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_blank <= 1'b0;
      frame_cnt <= '0;
    end else if (frame_end) begin
      cur_blank <= blank_req;
      frame_cnt <= frame_cnt + FRAME_W'(1);
    end
  end

  rtg_pixel #(.CW(CW)) u_pix (
    .in_lim_i(!hblank_o && !vblank_o), .border_i(h_bdr || v_bdr),
    .cur_blank_i(cur_blank), .de_mode_i(de_mode),
    .pix_i, .blank_col_i(blank_col), .ovs_col_i(ovs_col),
    .pix_o, .de_o
  );
endmodule

// File: rtl/rtg_checks.sv
module rtg_checks #(
  parameter int CNT_W   = 12,
  parameter int FRAME_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run,
  input logic [CNT_W-1:0]   hcnt,
  input logic [CNT_W-1:0]   vcnt,
  input logic [CNT_W-1:0]   htot,
  input logic               frame_end,
  input logic [FRAME_W-1:0] frame_cnt,
  input logic               cur_blank,
  input logic               de_mode,
  input logic               de_o,
  input logic               hblank_o,
  input logic               vblank_o
);
  assert_h_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && (hcnt < htot) |=> hcnt == CNT_W'($past(hcnt) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(hcnt) && $stable(vcnt) && $stable(frame_cnt));

  assert_de_inside_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !hblank_o && !vblank_o);

  assert_blank_at_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(cur_blank));

  assert_de_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_blank && de_mode |-> !de_o);

  assert_frame_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> frame_cnt == FRAME_W'($past(frame_cnt) + 1'b1));

  assert_frame_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(frame_cnt));

  assert_wrap_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && (hcnt >= htot) |=> hcnt == '0);
endmodule

bind raster_timing_gen rtg_checks #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .hcnt(hcnt), .vcnt(vcnt), .htot(htot),
  .frame_end(frame_end), .frame_cnt(frame_cnt), .cur_blank(cur_blank),
  .de_mode(de_mode), .de_o(de_o), .hblank_o(hblank_o), .vblank_o(vblank_o)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [23:0] pix_i = '0;
  logic [23:0] pix_o;
  logic hsync_o, vsync_o, hblank_o, vblank_o, de_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [23:0] BLK = 24'h405060;
  localparam logic [23:0] OVS = 24'h102030;

  raster_timing_gen uut (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .pix_i, .pix_o, .hsync_o, .vsync_o, .hblank_o, .vblank_o, .de_o
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wait_pos(input int h, input int v);
    logic [31:0] p;
    for (int i = 0; i < 600; i++) begin
      rd(4'hA, p);
      if (p[15:0] == 16'(h) && p[31:16] == 16'(v)) return;
      @(negedge clk_i);
    end
    check(1'b0, "wait_pos", p, {16'(v), 16'(h)});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'hA, d); check(d == 0, "R2 reset pos", d, 0);
    rd(4'hB, d); check(d == 0, "R2 reset frames", d, 0);
    rd(4'h6, d); check(d[8] == 0, "R7 reset blank state", d, 0);
    check(de_o == 0, "R4 reset de", de_o, 0);
    check(pix_o == 0, "R6 reset pix", pix_o, 0);
    check(hsync_o == 1 && vsync_o == 1, "R5 reset sync", {hsync_o, vsync_o}, 2'b11);
  endtask

  task automatic t_program();
    logic [31:0] d;
    wr(4'h1, 19);
    wr(4'h2, 9);
    wr(4'h3, {16'd16, 16'd4});
    wr(4'h4, {16'd8, 16'd2});
    wr(4'h5, {8'd1, 8'd1, 8'd1, 8'd2});
    wr(4'h7, BLK);
    wr(4'h8, OVS);
    rd(4'h1, d); check(d == 19, "R12 htot", d, 19);
    rd(4'h3, d); check(d == {16'd16, 16'd4}, "R12 hblk", d, {16'd16, 16'd4});
    rd(4'h5, d); check(d == 32'h01010102, "R12 border", d, 32'h01010102);
  endtask

  task automatic t_scan();
    logic [31:0] d;
    wr(4'h0, 1);
    for (int k = 0; k < 400; k++) begin
      int h, v;
      bit hb, vb, bdr, de_e;
      logic [23:0] pe;
      h = k % 20; v = (k / 20) % 10;
      pix_i = {8'(h), 8'(v), 8'h5A};
      #1;
      hb = (h < 4) || (h >= 16);
      vb = (v < 2) || (v >= 8);
      bdr = (h < 6) || (h >= 15) || (v < 3) || (v >= 7);
      de_e = !hb && !vb && !bdr;
      pe = (hb || vb) ? 24'h0 : (bdr ? OVS : pix_i);
      check(hblank_o == hb && vblank_o == vb, "R1 R3 blank flags", {hblank_o, vblank_o}, {hb, vb});
      check(de_o == de_e, "R4 de", de_o, de_e);
      check(hsync_o == (h < 2) && vsync_o == (v < 1), "R5 sync", {hsync_o, vsync_o}, {h < 2, v < 1});
      check(pix_o == pe, "R6 pixel", pix_o, pe);
      @(negedge clk_i);
    end
    rd(4'hB, d); check(d == 2, "R10 frames after two", d, 2);
  endtask

  task automatic t_position();
    logic [31:0] p1, p2, s;
    bit vb;
    rd(4'hA, p1);
    rd(4'h9, s);
    vb = (p1[31:16] < 2) || (p1[31:16] >= 8);
    check(s[0] == vb, "R9 status vblank", s, vb);
    @(negedge clk_i);
    rd(4'hA, p2);
    check(p1 != p2, "R9 position moves", p2, p1);
  endtask

  task automatic t_blank();
    logic [31:0] d;
    wait_pos(10, 4);
    wr(4'h6, 1);
    rd(4'h6, d); check(d[8] == 0, "R7 pending not applied", d, 0);
    pix_i = 24'hC0FFEE; #1;
    check(pix_o == 24'hC0FFEE, "R7 pending pix", pix_o, 24'hC0FFEE);
    wait_pos(0, 0);
    rd(4'h6, d); check(d[8] == 1, "R7 applied at frame", d, 32'h101);
    wait_pos(10, 4);
    check(pix_o == BLK, "R7 blank colour", pix_o, BLK);
    check(de_o == 1, "R8 de kept without mode", de_o, 1);
    wr(4'h6, 3);
    check(de_o == 0, "R8 de forced low", de_o, 0);
    wr(4'h6, 0);
    rd(4'h6, d); check(d[8] == 1, "R7 unblank pending", d, 32'h100);
    check(pix_o == BLK, "R7 still blank", pix_o, BLK);
    wait_pos(0, 0);
    rd(4'h6, d); check(d[8] == 0, "R7 unblank applied", d, 0);
    wait_pos(10, 4);
    pix_i = 24'h123456; #1;
    check(pix_o == 24'h123456 && de_o == 1, "R7 pass after unblank", {de_o, pix_o}, {1'b1, 24'h123456});
  endtask

  task automatic t_shrink();
    logic [31:0] d;
    wait_pos(15, 3);
    wr(4'h1, 9);
    @(negedge clk_i);
    rd(4'hA, d);
    check(d == {16'd4, 16'd0}, "R11 wrap above lowered total", d, {16'd4, 16'd0});
    wr(4'h1, 19);
  endtask

  task automatic t_stop();
    logic [31:0] p1, f1, p2, f2;
    wr(4'h0, 0);
    rd(4'hA, p1); rd(4'hB, f1);
    repeat (30) @(negedge clk_i);
    rd(4'hA, p2); rd(4'hB, f2);
    check(p1 == p2, "R2 position held", p2, p1);
    check(f1 == f2, "R2 frames held", f2, f1);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_program();
    t_scan();
    t_position();
    t_blank();
    t_shrink();
    t_stop();
    summary();
  end
endmodule